// File: doc/BRIEF.md
# Circular-Buffer Data Address Generator

This block generates operand addresses for a memory port, so the arithmetic units never spend cycles on address math. It holds eight pointer (index) registers, eight modify registers, eight length registers and eight base registers. Each of these registers has a second, alternate copy, so an interrupt handler can switch context in one cycle.

An access request names a pointer, a modify register and a mode. In post-modify mode the current pointer goes out as the address. The pointer is then advanced by the modify value and written back. When the paired length is non-zero, the advance wraps within a circular buffer that starts at the paired base, at any alignment. In pre-modify mode the address is pointer plus modify and the pointer stays unchanged. Bit-reverse mode mirrors the low address bits for FFT reordering.

The address width is a parameter: one instance can serve data memory at 32 bits and another program memory at 24 bits.

Top module: `circ_agen`

## Requirements
- R1: After reset every register in both copies reads zero and `addr_vld` is low.
- R2: When `wr_en` is high, `wr_data` is written at the clock edge into the register chosen by `wr_idx` and `wr_kind` (0 pointer, 1 modify, 2 length, 3 base). `rd_data` returns the register chosen by `rd_idx`/`rd_kind` combinationally.
- R3: A post-modify access (`acc_pre`=0) drives the pointer value on `addr_out` one clock after the request. The pointer is replaced by its advanced value.
- R4: With a non-zero length L, base B and sum S = I+M (M in two's complement): if S >= B+L the new pointer is S-L, if S < B it is S+L, otherwise it is S. The modify magnitude is assumed not to exceed L.
- R5: With a length of zero the pointer advances linearly to I+M with no wrap.
- R6: A pre-modify access (`acc_pre`=1) outputs I+M without wrap and leaves the pointer unchanged.
- R7: With `acc_brev` high, address bits [BRW-1:0] (BRW=8 by default) are output in reversed order and the bits above pass through unchanged.
- R8: `ctx_lo` picks the copy (0 primary, 1 alternate) for register sets 0-3 and `ctx_hi` for sets 4-7, independently. The copy choice applies to reads, writes and accesses.
- R9: `addr_vld` is high exactly in the cycle after each request cycle. `addr_out` holds its last value while no request is made.
- R10: If a register write targets the pointer that a post-modify access updates in the same cycle, the written value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctx_lo | input | 1 | Copy select for register sets 0-3 |
| ctx_hi | input | 1 | Copy select for register sets 4-7 |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 2 | Register kind for write |
| wr_idx | input | 3 | Register set for write |
| wr_data | input | AW | Write data |
| rd_kind | input | 2 | Register kind for read |
| rd_idx | input | 3 | Register set for read |
| rd_data | output | AW | Read data |
| acc_en | input | 1 | Access request |
| acc_idx | input | 3 | Pointer / length / base set used |
| acc_mod | input | 3 | Modify register used |
| acc_pre | input | 1 | 1 pre-modify, 0 post-modify |
| acc_brev | input | 1 | Bit-reverse the output address |
| addr_out | output | AW | Generated address |
| addr_vld | output | 1 | Address valid |

## Verification
The wrap-range assertion presumes that the pointer already lies inside its buffer and that the modify magnitude does not exceed the length. It fires only when both hold. The stimulus loads each circular pointer inside [B, B+L) and uses modify values of 3 and -4 against lengths of 5 and 10. It also steps a pointer onto exactly B+L and below B, so both wrap branches are exercised. Every address space used sits far from the top and bottom of the address range, so the unsigned sums never overflow.

// File: rtl/circ_agen.sv
module circ_agen #(
  parameter int AW   = 32,
  parameter int NREG = 8,
  parameter int BRW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctx_lo,
  input  logic          ctx_hi,
  input  logic          wr_en,
  input  logic [1:0]    wr_kind,
  input  logic [2:0]    wr_idx,
  input  logic [AW-1:0] wr_data,
  input  logic [1:0]    rd_kind,
  input  logic [2:0]    rd_idx,
  output logic [AW-1:0] rd_data,
  input  logic          acc_en,
  input  logic [2:0]    acc_idx,
  input  logic [2:0]    acc_mod,
  input  logic          acc_pre,
  input  logic          acc_brev,
  output logic [AW-1:0] addr_out,
  output logic          addr_vld
);
  localparam int IW = $clog2(NREG);

  logic [AW-1:0] regs [2][4][NREG];

  logic c_acc, c_mod, c_wr, c_rd;
  assign c_acc = acc_idx[IW-1] ? ctx_hi : ctx_lo;
  assign c_mod = acc_mod[IW-1] ? ctx_hi : ctx_lo;
  assign c_wr  = wr_idx[IW-1]  ? ctx_hi : ctx_lo;
  assign c_rd  = rd_idx[IW-1]  ? ctx_hi : ctx_lo;

  assign rd_data = regs[c_rd][rd_kind][rd_idx];

  logic [AW-1:0] cur_i, cur_m, cur_l, cur_b, sum, top, nxt_i, raw, addr_nx;
  logic [BRW-1:0] rev_lo;

  assign cur_i = regs[c_acc][0][acc_idx];
  assign cur_m = regs[c_mod][1][acc_mod];
  assign cur_l = regs[c_acc][2][acc_idx];
  assign cur_b = regs[c_acc][3][acc_idx];
  assign sum   = cur_i + cur_m;
  assign top   = cur_b + cur_l;

  always_comb begin
    nxt_i = sum;
    if (cur_l != '0) begin
      if (sum >= top)        nxt_i = sum - cur_l;
      else if (sum < cur_b)  nxt_i = sum + cur_l;
    end
  end

  assign raw = acc_pre ? sum : cur_i;

  for (genvar k = 0; k < BRW; k++) begin : g_rev
    assign rev_lo[k] = raw[BRW-1-k];
  end

  assign addr_nx = acc_brev ? {raw[AW-1:BRW], rev_lo} : raw;

  logic wb_en, wr_hit;
  assign wr_hit = wr_en && (wr_kind == 2'd0) && (wr_idx == acc_idx) && (c_wr == c_acc);
  assign wb_en  = acc_en && !acc_pre && !wr_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++)
        for (int k = 0; k < 4; k++)
          for (int n = 0; n < NREG; n++)
            regs[c][k][n] <= '0;
      addr_out <= '0;
      addr_vld <= 1'b0;
    end else begin
      if (wr_en) regs[c_wr][wr_kind][wr_idx] <= wr_data;
      if (wb_en) regs[c_acc][0][acc_idx] <= nxt_i;
      if (acc_en) addr_out <= addr_nx;
      addr_vld <= acc_en;
    end
  end
endmodule

module circ_agen_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_en,
  input logic          acc_pre,
  input logic          addr_vld,
  input logic [AW-1:0] addr_out,
  input logic [AW-1:0] cur_i,
  input logic [AW-1:0] cur_m,
  input logic [AW-1:0] cur_l,
  input logic [AW-1:0] cur_b,
  input logic [AW-1:0] nxt_i
);
  logic in_buf, mod_ok;
  assign in_buf = (cur_i >= cur_b) && (cur_i < cur_b + cur_l);
  assign mod_ok = ($signed(cur_m) <= $signed(cur_l)) && ($signed(cur_m) >= -$signed(cur_l));

  a_r4_wrap_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_pre && cur_l != '0 && in_buf && mod_ok) |->
      (nxt_i >= cur_b && nxt_i < cur_b + cur_l));

  a_r5_linear: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && cur_l == '0) |-> (nxt_i == cur_i + cur_m));

  a_r9_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en |=> addr_vld);

  a_r9_vld_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |=> !addr_vld);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |=> $stable(addr_out));
endmodule

bind circ_agen circ_agen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_pre(acc_pre),
  .addr_vld(addr_vld), .addr_out(addr_out), .cur_i(cur_i), .cur_m(cur_m),
  .cur_l(cur_l), .cur_b(cur_b), .nxt_i(nxt_i)
);

// File: tb/circ_agen_tb.sv
`timescale 1ns/1ps
module circ_agen_tb;
  localparam int AW = 32;
  localparam int BRW = 8;

  logic clk = 0, rst_n = 0;
  logic ctx_lo = 0, ctx_hi = 0, wr_en = 0, acc_en = 0, acc_pre = 0, acc_brev = 0;
  logic [1:0] wr_kind = 0, rd_kind = 0;
  logic [2:0] wr_idx = 0, rd_idx = 0, acc_idx = 0, acc_mod = 0;
  logic [AW-1:0] wr_data = 0, rd_data, addr_out;
  logic addr_vld;

  always #2.5 clk = ~clk;

  circ_agen #(.AW(AW), .NREG(8), .BRW(BRW)) u_dut (.*);

  int total = 0, bad = 0;
  logic [AW-1:0] mdl [2][4][8];
  logic [AW-1:0] exp_q [$];
  string tag_q [$];
  logic [AW-1:0] last_addr = 0;

  function automatic logic cp(input logic [2:0] i);
    return i[2] ? ctx_hi : ctx_lo;
  endfunction

  function automatic logic [AW-1:0] brev(input logic [AW-1:0] a);
    logic [AW-1:0] r = a;
    for (int k = 0; k < BRW; k++) r[k] = a[BRW-1-k];
    return r;
  endfunction

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] k, input logic [2:0] i, input logic [AW-1:0] d);
    @(posedge clk); #1;
    wr_en = 1; wr_kind = k; wr_idx = i; wr_data = d;
    mdl[cp(i)][k][i] = d;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic rd(input string req, input logic [1:0] k, input logic [2:0] i);
    @(negedge clk);
    rd_kind = k; rd_idx = i;
    #0.5;
    chk(req, rd_data, mdl[cp(i)][k][i]);
  endtask

  task automatic acc(input string req, input logic [2:0] p, input logic [2:0] m,
                     input logic pre, input logic bv, input logic clash = 0,
                     input logic [AW-1:0] cd = 0);
    logic [AW-1:0] i, mv, l, b, s, n, a;
    @(posedge clk); #1;
    i = mdl[cp(p)][0][p]; mv = mdl[cp(m)][1][m];
    l = mdl[cp(p)][2][p]; b = mdl[cp(p)][3][p];
    s = i + mv;
    n = s;
    if (l != 0 && s >= b + l) n = s - l;
    else if (l != 0 && s < b) n = s + l;
    a = pre ? s : i;
    if (bv) a = brev(a);
    exp_q.push_back(a); tag_q.push_back(req);
    last_addr = a;
    acc_en = 1; acc_idx = p; acc_mod = m; acc_pre = pre; acc_brev = bv;
    if (clash) begin
      wr_en = 1; wr_kind = 0; wr_idx = p; wr_data = cd;
      mdl[cp(p)][0][p] = cd;
    end else if (!pre) mdl[cp(p)][0][p] = n;
    @(posedge clk); #1;
    acc_en = 0; acc_pre = 0; acc_brev = 0; wr_en = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && addr_vld) begin
      if (exp_q.size() == 0) chk("R9 unexpected valid", 1, 0);
      else chk(tag_q.pop_front(), addr_out, exp_q.pop_front());
    end
  end

  bit done = 0;
  initial begin
    #200000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 2; c++)
      for (int k = 0; k < 4; k++)
        for (int n = 0; n < 8; n++) mdl[c][k][n] = 0;
    #1;
    @(negedge clk); @(negedge clk);
    chk("R1 vld low", addr_vld, 0);
    rd("R1 reset ptr", 0, 0);
    rd("R1 reset base", 3, 7);
    rst_n = 1;

    wr(3, 0, 100); wr(2, 0, 10); wr(0, 0, 105); wr(1, 0, 3);
    wr(1, 1, 32'hFFFF_FFFC);
    rd("R2 readback len", 2, 0);
    rd("R2 readback mod", 1, 1);
    for (int n = 0; n < 5; n++) acc("R3/R4 post wrap up", 0, 0, 0, 0);
    rd("R4 hit top goes to base", 0, 0);
    acc("R4 wrap down", 0, 1, 0, 0);
    acc("R4 after wrap down", 0, 1, 0, 0);
    rd("R4 pointer", 0, 0);

    wr(0, 2, 50); wr(1, 2, 7);
    acc("R5 linear", 2, 2, 0, 0);
    acc("R5 linear", 2, 2, 0, 0);
    rd("R5 pointer", 0, 2);
    acc("R6 pre", 2, 2, 1, 0);
    rd("R6 pointer unchanged", 0, 2);

    wr(3, 3, 32'h1003); wr(2, 3, 5); wr(0, 3, 32'h1006);
    acc("R4 unaligned base", 3, 0, 0, 0);
    acc("R4 unaligned base", 3, 0, 0, 0);
    rd("R4 unaligned pointer", 0, 3);

    wr(0, 4, 32'h1201); wr(1, 5, 1);
    acc("R7 brev", 4, 5, 0, 1);
    acc("R7 brev", 4, 5, 0, 1);
    acc("R7 brev pre", 4, 5, 1, 1);

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 idle vld", addr_vld, 0);
    chk("R9 hold addr", addr_out, last_addr);

    ctx_lo = 1;
    rd("R8 alt empty", 0, 0);
    wr(0, 0, 500); wr(1, 0, 2);
    rd("R8 alt ptr", 0, 0);
    rd("R8 hi primary", 0, 4);
    acc("R8 alt access", 0, 0, 0, 0);
    rd("R8 alt ptr after", 0, 0);
    ctx_lo = 0;
    rd("R8 primary kept", 0, 0);
    ctx_hi = 1;
    rd("R8 hi alt", 0, 4);
    ctx_hi = 0;
    rd("R8 hi primary back", 0, 4);

    acc("R10 clash addr", 0, 0, 0, 0, 1, 32'h0000_0066);
    rd("R10 write wins", 0, 0);

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 queue drained", exp_q.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule